// File: doc/BRIEF.md
# Three-Level Word Permission Walker

This block finds the 2-bit access right that applies to one 32-bit word address by walking a trie of permission tables kept in ordinary memory. A caller hands it an address together with the root table pointer of the active protection domain. The walker then fetches one table word at a time through a single read port. It returns the permission code, the level at which the walk stopped and the base-2 logarithm of the byte span that the code covers. A protection cache uses that span when it refills.

There are three table levels. The top level covers 256 KB slices, the middle level covers 256 B slices and the leaf level covers single words. An entry at either of the two upper levels carries a type flag. A pointer entry sends the walk down to the next table. A data entry ends the walk at once, and its permission applies to the whole slice. The leaf level packs sixteen 2-bit codes into each memory word, so a region can start and end on any word boundary. Each request is handled completely before the next one is accepted. Each memory response may arrive after any number of cycles.

Top module: `perm_walker`

## Requirements
- R1: While reset is asserted and after it is released, req_ready_o is 1, done_o is 0 and mem_rd_o is 0.
- R2: The first read goes to the root pointer with its bits [1:0] cleared, plus 4 times address bits [31:18]. The root pointer's bits [1:0] have no effect on the result.
- R3: An upper-level entry with bit 0 = 1 is a pointer. The next table base is the entry with bits [1:0] cleared. An upper-level entry with bit 0 = 0 is data, and its permission is bits [2:1]. Codes: 0 none, 1 read-only, 2 read-write, 3 execute-read.
- R4: A data entry at the top level ends the walk after exactly one read, with level_o = 1 and region_lg2_o = 18.
- R5: The second read goes to the middle table base plus 4 times address bits [17:8]. A data entry there ends the walk after two reads, with level_o = 2 and region_lg2_o = 8.
- R6: The third read goes to the leaf table base plus 4 times address bits [7:6]. The permission is bits [2k+1:2k] of that word, with k = address bits [5:2]. The walk ends after three reads, with level_o = 3 and region_lg2_o = 2.
- R7: req_ready_o is high only while no walk is in progress, so one request is accepted at a time. done_o is a one-cycle pulse, and req_ready_o is already high in that cycle.
- R8: mem_rd_o stays high with a stable, word-aligned mem_addr_o until mem_rvalid_i arrives. The result is the same for any response latency.
- R9: Bits [31:3] of an upper-level data entry, and bit 1 of a pointer entry, have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request valid |
| req_ready_o | output | 1 | Walker idle, request accepted |
| req_addr_i | input | 32 | Word address to look up |
| req_root_i | input | 32 | Root table pointer of the active domain |
| mem_rd_o | output | 1 | Read request, held until response |
| mem_addr_o | output | 32 | Byte address of the table word |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| done_o | output | 1 | One-cycle result pulse |
| perm_o | output | 2 | Permission code |
| level_o | output | 2 | Level at which the walk ended (1..3) |
| region_lg2_o | output | 6 | log2 of the byte span covered by perm_o |

## Verification
The bench builds the walker with its default parameters: 32-bit addresses, level boundaries at bits 18, 8 and 2, and 32-bit table words. With these values every top-level index maps to a distinct table word, and the sixteen leaf lanes of a packed word can be reached by random addresses. Random table bases in three separate address ranges, random filler bits in the entries and response latencies of zero to three cycles exercise early stops at each level. Any wrong index field or wrong entry address sends a read to an empty location, and that location returns a different result.

// File: rtl/perm_walker_pkg.sv
package perm_walker_pkg;
  typedef enum logic [1:0] {
    PERM_NONE = 2'd0,
    PERM_RO   = 2'd1,
    PERM_RW   = 2'd2,
    PERM_XR   = 2'd3
  } perm_e;

  typedef enum logic [1:0] {
    LVL_NONE = 2'd0,
    LVL_TOP  = 2'd1,
    LVL_MID  = 2'd2,
    LVL_LEAF = 2'd3
  } lvl_e;

  typedef enum logic {
    ST_IDLE,
    ST_READ
  } st_e;
endpackage

// File: rtl/perm_walker_index.sv
module perm_walker_index
  import perm_walker_pkg::*;
#(
  parameter int AW     = 32,
  parameter int L1_LO  = 18,
  parameter int L2_LO  = 8,
  parameter int L3_LO  = 2,
  parameter int LANE_W = 4,
  parameter int BO     = 2
) (
  input  logic [AW-1:0]     va_i,
  input  lvl_e              lvl_i,
  input  logic [AW-1:0]     ptr_i,
  output logic [AW-1:0]     addr_o,
  output logic [LANE_W-1:0] lane_o
);
  localparam int I1  = AW - L1_LO;
  localparam int I2  = L1_LO - L2_LO;
  localparam int I3  = L2_LO - L3_LO;
  localparam int SEL = I3 - LANE_W;

  logic [I1-1:0]  idx1;
  logic [I2-1:0]  idx2;
  logic [I3-1:0]  idx3;
  logic [SEL-1:0] sel3;
  logic [AW-1:0]  off;

  always_comb begin
    idx1   = va_i[AW-1:L1_LO];
    idx2   = va_i[L1_LO-1:L2_LO];
    idx3   = va_i[L2_LO-1:L3_LO];
    sel3   = idx3[I3-1:LANE_W];
    lane_o = idx3[LANE_W-1:0];
    unique case (lvl_i)
      LVL_TOP:  off = AW'(idx1) << BO;
      LVL_MID:  off = AW'(idx2) << BO;
      LVL_LEAF: off = AW'(sel3) << BO;
      default:  off = '0;
    endcase
    addr_o = ptr_i + off;
  end
endmodule

// File: rtl/perm_walker_decode.sv
module perm_walker_decode
  import perm_walker_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int LANE_W = 4,
  parameter int BO     = 2
) (
  input  logic [DW-1:0]     word_i,
  input  lvl_e              lvl_i,
  input  logic [LANE_W-1:0] lane_i,
  output logic              is_ptr_o,
  output logic [AW-1:0]     next_o,
  output perm_e             perm_o
);
  localparam int LANES = 1 << LANE_W;

  logic [1:0] lane_perm [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_perm[g] = word_i[2*g +: 2];
  end

  always_comb begin
    is_ptr_o = (lvl_i != LVL_LEAF) && word_i[0];
    next_o   = {word_i[AW-1:BO], {BO{1'b0}}};
    if (lvl_i == LVL_LEAF) perm_o = perm_e'(lane_perm[lane_i]);
    else                   perm_o = perm_e'(word_i[2:1]);
  end
endmodule

// File: rtl/perm_walker.sv
module perm_walker
  import perm_walker_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int L1_LO  = 18,
  parameter int L2_LO  = 8,
  parameter int L3_LO  = 2,
  parameter int SPAN_W = $clog2(AW + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [AW-1:0]     req_root_i,
  output logic              mem_rd_o,
  output logic [AW-1:0]     mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [DW-1:0]     mem_rdata_i,
  output logic              done_o,
  output logic [1:0]        perm_o,
  output logic [1:0]        level_o,
  output logic [SPAN_W-1:0] region_lg2_o
);
  localparam int BO     = $clog2(DW / 8);
  localparam int LANE_W = $clog2(DW / 2);

  st_e             st_q;
  lvl_e            lvl_q, lvl_out_q;
  logic [AW-1:0]   va_q, ptr_q;
  logic            done_q;
  perm_e           perm_q;

  logic [LANE_W-1:0] lane;
  logic              is_ptr;
  logic [AW-1:0]     next_ptr;
  perm_e             perm_dec;

  perm_walker_index #(
    .AW(AW), .L1_LO(L1_LO), .L2_LO(L2_LO), .L3_LO(L3_LO),
    .LANE_W(LANE_W), .BO(BO)
  ) u_index (
    .va_i  (va_q),
    .lvl_i (lvl_q),
    .ptr_i (ptr_q),
    .addr_o(mem_addr_o),
    .lane_o(lane)
  );

  perm_walker_decode #(
    .AW(AW), .DW(DW), .LANE_W(LANE_W), .BO(BO)
  ) u_decode (
    .word_i  (mem_rdata_i),
    .lvl_i   (lvl_q),
    .lane_i  (lane),
    .is_ptr_o(is_ptr),
    .next_o  (next_ptr),
    .perm_o  (perm_dec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      lvl_q     <= LVL_NONE;
      lvl_out_q <= LVL_NONE;
      va_q      <= '0;
      ptr_q     <= '0;
      done_q    <= 1'b0;
      perm_q    <= PERM_NONE;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          va_q  <= req_addr_i;
          ptr_q <= {req_root_i[AW-1:BO], {BO{1'b0}}};
          lvl_q <= LVL_TOP;
          st_q  <= ST_READ;
        end
        ST_READ: if (mem_rvalid_i) begin
          if (is_ptr) begin
            ptr_q <= next_ptr;
            lvl_q <= lvl_e'(2'(lvl_q + 2'd1));
          end else begin
            done_q    <= 1'b1;
            perm_q    <= perm_dec;
            lvl_out_q <= lvl_q;
            lvl_q     <= LVL_NONE;
            st_q      <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready_o = (st_q == ST_IDLE);
    mem_rd_o    = (st_q == ST_READ);
    done_o      = done_q;
    perm_o      = perm_q;
    level_o     = lvl_out_q;
    unique case (lvl_out_q)
      LVL_TOP:  region_lg2_o = SPAN_W'(L1_LO);
      LVL_MID:  region_lg2_o = SPAN_W'(L2_LO);
      LVL_LEAF: region_lg2_o = SPAN_W'(L3_LO);
      default:  region_lg2_o = '0;
    endcase
  end
endmodule

// File: rtl/perm_walker_chk.sv
module perm_walker_chk #(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int SPAN_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              mem_rd_o,
  input logic [AW-1:0]     mem_addr_o,
  input logic              mem_rvalid_i,
  input logic              done_o,
  input logic [1:0]        level_o,
  input logic [SPAN_W-1:0] region_lg2_o
);
  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> !req_ready_o); // R7
  AST_ACCEPT_STARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> mem_rd_o); // R7
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> req_ready_o); // R7
  AST_HOLD_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o && !mem_rvalid_i |=> mem_rd_o && $stable(mem_addr_o)); // R8
  AST_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> mem_addr_o[1:0] == 2'b00); // R8
  AST_DONE_AFTER_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(mem_rvalid_i)); // R8
  AST_LEVEL_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> level_o != 2'd0 && region_lg2_o != '0); // R4
endmodule

bind perm_walker perm_walker_chk #(.AW(AW), .DW(DW), .SPAN_W(SPAN_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .mem_rd_o    (mem_rd_o),
  .mem_addr_o  (mem_addr_o),
  .mem_rvalid_i(mem_rvalid_i),
  .done_o      (done_o),
  .level_o     (level_o),
  .region_lg2_o(region_lg2_o)
);

// File: tb/perm_walker_test.sv
module perm_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [31:0] req_root = '0;
  logic        mem_rd;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        done;
  logic [1:0]  perm;
  logic [1:0]  level;
  logic [5:0]  region_lg2;

  int total = 0;
  int bad = 0;
  int unsigned lat = 0;
  int reads = 0;
  logic [31:0] mem [int unsigned];

  always #2 clk = ~clk;

  perm_walker uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_root_i(req_root),
    .mem_rd_o(mem_rd), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .done_o(done), .perm_o(perm), .level_o(level), .region_lg2_o(region_lg2)
  );

  function automatic logic [31:0] fetch(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // R8: responses after 0..3 idle cycles
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (rst_n && mem_rd && !mem_rvalid) begin
      if (lat == 0) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= fetch(mem_addr);
        lat        <= $urandom_range(3, 0);
        reads      <= reads + 1;
      end else lat <= lat - 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // kind: 0 stop at top, 1 stop at middle, 2 leaf
  task automatic run_case(input int kind, input logic [1:0] p, input logic [31:0] va);
    logic [31:0] b1, b2, b3, w;
    int r0, wait_n;
    mem.delete();
    b1 = 32'h1000_0000 | ((32'($urandom) & 32'h0003_FFFF) << 2);
    b2 = 32'h2000_0000 | ((32'($urandom) & 32'h0003_FFFF) << 2);
    b3 = 32'h3000_0000 | ((32'($urandom) & 32'h0003_FFFF) << 2);
    w  = $urandom;
    if (kind == 0) begin
      mem[b1 + {va[31:18], 2'b00}] = {w[31:3], p, 1'b0};               // R3 R9
    end else begin
      mem[b1 + {va[31:18], 2'b00}] = {b2[31:2], w[1], 1'b1};           // R2 R9
      if (kind == 1) begin
        mem[b2 + {va[17:8], 2'b00}] = {w[31:3], p, 1'b0};              // R5
      end else begin
        mem[b2 + {va[17:8], 2'b00}] = {b3[31:2], w[0], 1'b1};
        w[2*va[5:2] +: 2] = p;
        mem[b3 + {va[7:6], 2'b00}] = w;                                // R6
      end
    end
    @(negedge clk);
    chk("R7 ready before request", 32'(req_ready), 32'd1);
    r0 = reads;
    req_valid = 1'b1;
    req_addr  = va;
    req_root  = b1 | 32'($urandom_range(3, 0));                        // R2 low bits ignored
    @(negedge clk);
    req_valid = 1'b0;
    req_addr  = $urandom;
    chk("R7 ready low while busy", 32'(req_ready), 32'd0);
    wait_n = 0;
    while (!done && wait_n < 100) begin
      @(negedge clk);
      wait_n++;
    end
    if (!done) begin
      chk("R7 walk completes", 32'd0, 32'd1);
      return;
    end
    case (kind)
      0: begin
        chk("R4 perm", 32'(perm), 32'(p));
        chk("R4 level", 32'(level), 32'd1);
        chk("R4 span", 32'(region_lg2), 32'd18);
        chk("R4 reads", 32'(reads - r0), 32'd1);
      end
      1: begin
        chk("R5 perm", 32'(perm), 32'(p));
        chk("R5 level", 32'(level), 32'd2);
        chk("R5 span", 32'(region_lg2), 32'd8);
        chk("R5 reads", 32'(reads - r0), 32'd2);
      end
      default: begin
        chk("R6 perm", 32'(perm), 32'(p));
        chk("R6 level", 32'(level), 32'd3);
        chk("R6 span", 32'(region_lg2), 32'd2);
        chk("R6 reads", 32'(reads - r0), 32'd3);
      end
    endcase
    chk("R7 ready with done", 32'(req_ready), 32'd1);
    @(negedge clk);
    chk("R7 done one cycle", 32'(done), 32'd0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    chk("R1 ready in reset", 32'(req_ready), 32'd1);
    chk("R1 done in reset", 32'(done), 32'd0);
    chk("R1 no read in reset", 32'(mem_rd), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after reset", {30'd0, mem_rd, done}, 32'd0);
    // directed corners
    run_case(0, 2'd0, 32'h0000_0000);   // R3 none code at top
    run_case(0, 2'd3, 32'hFFFF_FFFC);   // R2 highest top index
    run_case(1, 2'd1, 32'h0003_FF00);   // R5 highest middle index
    run_case(2, 2'd2, 32'h0000_00FC);   // R6 last lane of last word
    run_case(2, 2'd3, 32'h0000_0000);   // R6 first lane
    for (int i = 0; i < 300; i++) begin
      run_case(int'($urandom_range(2, 0)), 2'($urandom_range(3, 1)), 32'($urandom));
    end
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    summary();
  end
endmodule